// File: doc/BRIEF.md
# USB Dual-Role Controller Interrupt Status Aggregator

This block gathers the system-level interrupt sources of a USB controller that can act as either device or host. Short event pulses from the line-state logic (wake-up, session request, disconnect) are caught in sticky status bits. Two level inputs (b_valid and the connector ID) are edge-detected into sticky bits as well. Software reads these bits and clears each one by writing a one to it.

Beside the sticky bits, the status word carries two read-only level bits that software can clear only at their cause. The first reports that the periodic transmit FIFO has drained to a selectable threshold while the periodic request queue still has room. The second is the summary of a two-level channel hierarchy: each host channel has a write-one-to-clear cause register and a cause mask. An all-channels vector ORs the unmasked causes of each channel, and status bit 25 ORs that vector.

A mask register and a global enable combine the status word into one registered interrupt line. Access goes through a simple word-addressed port with a write strobe and a combinational read-back. The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `otg_irq_status`

## Requirements
- R1: Status bit 31 (address 0) is set after the clock edge that sees a dev_resume_pulse while host_mode=0, or a host_rwake_pulse while host_mode=1. The pulse of the other mode has no effect.
- R2: Status bit 30 is set by host_sreq_pulse while host_mode=1, or by a rising edge of b_valid while host_mode=0. A b_valid edge in host mode and a session pulse in device mode have no effect.
- R3: Status bit 29 is set after the clock edge that sees disconn_pulse high.
- R4: Status bit 28 is set on any change of conn_id, rising or falling. The level seen in the first cycle after reset is taken as the reference and does not count as a change.
- R5: A write to address 0 clears each of bits 31:28 whose data bit is one and leaves bits whose data bit is zero unchanged. Without a set or a clear, a sticky bit holds its value.
- R6: When a set event and a write-one clear reach the same bit in the same cycle, the bit ends up set.
- R7: Status bit 26 is combinational. It is 1 when pq_free_slots is nonzero and, for ptx_lvl_full_sel=0, ptx_free_words is at least PTX_DEPTH/2, or, for ptx_lvl_full_sel=1, ptx_free_words equals PTX_DEPTH.
- R8: Channel c has a cause register at address 4+c, set by ch_evt[c*CAUSE_W+k], cleared by writing one (set wins), and a cause mask at address 4+NUM_CH+c. Bit c of the all-channels word at address 3 is the OR of cause AND mask. Status bit 25 is the OR of the all-channels word.
- R9: Writes to bits 27:0 of address 0 and to address 3 have no effect. Status bit 27 and bits 24:0 always read 0.
- R10: irq is registered. One cycle after the inputs change, it equals control bit 0 (address 2) AND the OR of status AND the mask register (address 1). The mask register holds bits 31:28, 26 and 25; its other bits read 0.
- R11: During and after reset, every status, mask, control, cause and cause-mask bit reads 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| dev_resume_pulse | input | 1 | Resume detected (device role) |
| host_rwake_pulse | input | 1 | Remote wakeup detected (host role) |
| host_sreq_pulse | input | 1 | Session request from the far end (host role) |
| b_valid | input | 1 | B-session valid level (device role, rising edge used) |
| disconn_pulse | input | 1 | Disconnect detected |
| conn_id | input | 1 | Connector ID level |
| ptx_free_words | input | LVL_W | Free words in the periodic transmit FIFO |
| pq_free_slots | input | Q_W | Free entries in the periodic request queue |
| ptx_lvl_full_sel | input | 1 | 0 = half-empty threshold, 1 = fully-empty threshold |
| ch_evt | input | NUM_CH*CAUSE_W | Per-channel cause event pulses, channel c in bits c*CAUSE_W upward |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| irq | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach from the ports is a set event and a write-one clear arriving on the same bit in the same cycle, both for a top-level sticky bit and for a channel cause bit. The stimulus table places a disconnect pulse in the same vector as a clear of bit 29. A directed step drives a channel event in the same cycle as a write to that channel's cause register. The mode-dependent sources are reached by switching host_mode between vectors while b_valid is held high. This shows that only a rise seen in device mode counts.

// File: rtl/otg_irq_pkg.sv
`timescale 1ns/1ps
package otg_irq_pkg;
  // status word bit positions
  localparam int BIT_WAKE = 31;
  localparam int BIT_SESS = 30;
  localparam int BIT_DISC = 29;
  localparam int BIT_CID  = 28;
  localparam int BIT_PTXE = 26;
  localparam int BIT_CHAN = 25;
  localparam int STICKY_N = 4;
  localparam int STICKY_LSB = 28;
  // implemented (maskable) status bits
  localparam logic [31:0] STS_IMPL = 32'hF600_0000;
  // register word addresses
  localparam int A_STS   = 0;
  localparam int A_MSK   = 1;
  localparam int A_CTL   = 2;
  localparam int A_ALLCH = 3;
  localparam int A_CAUSE0 = 4;

  typedef struct packed {
    logic wake;
    logic sess;
    logic disc;
    logic cid;
  } sticky_t;
endpackage

// File: rtl/otg_irq_rstsync.sv
`timescale 1ns/1ps
module otg_irq_rstsync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/otg_irq_edge.sv
`timescale 1ns/1ps
module otg_irq_edge #(
  parameter bit ANY_CHANGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic evt_o
);
  logic prev_q, prev_d;
  logic armed_q, armed_d;

  always_comb begin
    prev_d  = sig_i;
    armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end

  generate
    if (ANY_CHANGE) begin : g_any
      assign evt_o = armed_q & (sig_i ^ prev_q);
    end else begin : g_rise
      assign evt_o = armed_q & sig_i & ~prev_q;
    end
  endgenerate
endmodule

// File: rtl/otg_irq_w1c.sv
`timescale 1ns/1ps
module otg_irq_w1c #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] bits_q, bits_d;
  logic         upd;

  // set has priority over a same-cycle clear
  always_comb begin
    bits_d = (bits_q & ~clr_i) | set_i;
    upd    = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bits_q <= '0;
    else if (upd) bits_q <= bits_d;
  end

  assign q_o = bits_q;
endmodule

// File: rtl/otg_irq_ptxe.sv
`timescale 1ns/1ps
module otg_irq_ptxe #(
  parameter int DEPTH = 256,
  parameter int LVL_W = 9,
  parameter int Q_W   = 4
) (
  input  logic [LVL_W-1:0] free_words_i,
  input  logic [Q_W-1:0]   q_slots_i,
  input  logic             full_sel_i,
  output logic             empty_o
);
  localparam int HALF = DEPTH / 2;

  logic half_ok, full_ok, room_ok;

  always_comb begin
    half_ok = (free_words_i >= LVL_W'(HALF));
    full_ok = (free_words_i >= LVL_W'(DEPTH));
    room_ok = (q_slots_i != '0);
    empty_o = (full_sel_i ? full_ok : half_ok) & room_ok;
  end
endmodule

// File: rtl/otg_irq_status.sv
`timescale 1ns/1ps
module otg_irq_status
  import otg_irq_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int CAUSE_W   = 8,
  parameter int PTX_DEPTH = 256,
  parameter int PQ_DEPTH  = 8,
  parameter int ADDR_W    = 6,
  localparam int LVL_W    = $clog2(PTX_DEPTH + 1),
  localparam int Q_W      = $clog2(PQ_DEPTH + 1),
  localparam int CH_BITS  = NUM_CH * CAUSE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_mode,
  input  logic               dev_resume_pulse,
  input  logic               host_rwake_pulse,
  input  logic               host_sreq_pulse,
  input  logic               b_valid,
  input  logic               disconn_pulse,
  input  logic               conn_id,
  input  logic [LVL_W-1:0]   ptx_free_words,
  input  logic [Q_W-1:0]     pq_free_slots,
  input  logic               ptx_lvl_full_sel,
  input  logic [CH_BITS-1:0] ch_evt,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq
);
  localparam int A_CMASK0 = A_CAUSE0 + NUM_CH;

  logic core_rst_n;

  // ---------------- reset release ----------------
  otg_irq_rstsync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rst_n)
  );

  // ---------------- level edge detection ----------------
  logic bv_rise, cid_chg;

  otg_irq_edge #(.ANY_CHANGE(1'b0)) u_bv_edge (
    .clk   (clk),
    .rst_n (core_rst_n),
    .sig_i (b_valid),
    .evt_o (bv_rise)
  );

  otg_irq_edge #(.ANY_CHANGE(1'b1)) u_cid_edge (
    .clk   (clk),
    .rst_n (core_rst_n),
    .sig_i (conn_id),
    .evt_o (cid_chg)
  );

  // ---------------- write decode ----------------
  logic wr_sts, wr_msk, wr_ctl;

  always_comb begin
    wr_sts = reg_we && (reg_addr == ADDR_W'(A_STS));
    wr_msk = reg_we && (reg_addr == ADDR_W'(A_MSK));
    wr_ctl = reg_we && (reg_addr == ADDR_W'(A_CTL));
  end

  // ---------------- sticky status bits ----------------
  sticky_t sticky_set, sticky_clr, sticky_q;
  logic [STICKY_N-1:0] sticky_bits;

  always_comb begin
    sticky_set.wake = host_mode ? host_rwake_pulse : dev_resume_pulse;
    sticky_set.sess = host_mode ? host_sreq_pulse  : bv_rise;
    sticky_set.disc = disconn_pulse;
    sticky_set.cid  = cid_chg;
    sticky_clr      = wr_sts ? sticky_t'(reg_wdata[BIT_WAKE:STICKY_LSB]) : '0;
  end

  otg_irq_w1c #(.W(STICKY_N)) u_sticky (
    .clk   (clk),
    .rst_n (core_rst_n),
    .set_i (sticky_set),
    .clr_i (sticky_clr),
    .q_o   (sticky_bits)
  );

  assign sticky_q = sticky_t'(sticky_bits);

  // ---------------- periodic FIFO empty ----------------
  logic ptxe_flag;

  otg_irq_ptxe #(.DEPTH(PTX_DEPTH), .LVL_W(LVL_W), .Q_W(Q_W)) u_ptxe (
    .free_words_i (ptx_free_words),
    .q_slots_i    (pq_free_slots),
    .full_sel_i   (ptx_lvl_full_sel),
    .empty_o      (ptxe_flag)
  );

  // ---------------- channel hierarchy ----------------
  logic [CAUSE_W-1:0] cause_q   [NUM_CH];
  logic [CAUSE_W-1:0] chmask_q  [NUM_CH];
  logic [CAUSE_W-1:0] chmask_d  [NUM_CH];
  logic [NUM_CH-1:0]  wr_cause;
  logic [NUM_CH-1:0]  wr_cmask;
  logic [NUM_CH-1:0]  allch;
  logic               chan_any;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic [CAUSE_W-1:0] cclr;

      always_comb begin
        wr_cause[c] = reg_we && (reg_addr == ADDR_W'(A_CAUSE0 + c));
        wr_cmask[c] = reg_we && (reg_addr == ADDR_W'(A_CMASK0 + c));
        cclr        = wr_cause[c] ? reg_wdata[CAUSE_W-1:0] : '0;
        chmask_d[c] = wr_cmask[c] ? reg_wdata[CAUSE_W-1:0] : chmask_q[c];
      end

      otg_irq_w1c #(.W(CAUSE_W)) u_cause (
        .clk   (clk),
        .rst_n (core_rst_n),
        .set_i (ch_evt[c*CAUSE_W +: CAUSE_W]),
        .clr_i (cclr),
        .q_o   (cause_q[c])
      );

      always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n)      chmask_q[c] <= '0;
        else if (wr_cmask[c]) chmask_q[c] <= chmask_d[c];
      end

      assign allch[c] = |(cause_q[c] & chmask_q[c]);
    end
  endgenerate

  assign chan_any = |allch;

  // ---------------- assembled status word ----------------
  logic [31:0] sts_view;

  always_comb begin
    sts_view           = '0;
    sts_view[BIT_WAKE] = sticky_q.wake;
    sts_view[BIT_SESS] = sticky_q.sess;
    sts_view[BIT_DISC] = sticky_q.disc;
    sts_view[BIT_CID]  = sticky_q.cid;
    sts_view[BIT_PTXE] = ptxe_flag;
    sts_view[BIT_CHAN] = chan_any;
  end

  // ---------------- mask, control, interrupt line ----------------
  logic [31:0] mask_q, mask_d;
  logic        ctl_en_q, ctl_en_d;
  logic        irq_q, irq_d;

  always_comb begin
    mask_d   = wr_msk ? (reg_wdata & STS_IMPL) : mask_q;
    ctl_en_d = wr_ctl ? reg_wdata[0] : ctl_en_q;
    irq_d    = ctl_en_q & |(sts_view & mask_q);
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      mask_q   <= '0;
      ctl_en_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_msk) mask_q   <= mask_d;
      if (wr_ctl) ctl_en_q <= ctl_en_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  // ---------------- read-back ----------------
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_STS))   reg_rdata = sts_view;
    if (reg_addr == ADDR_W'(A_MSK))   reg_rdata = mask_q;
    if (reg_addr == ADDR_W'(A_CTL))   reg_rdata[0] = ctl_en_q;
    if (reg_addr == ADDR_W'(A_ALLCH)) reg_rdata[NUM_CH-1:0] = allch;
    for (int k = 0; k < NUM_CH; k++) begin
      if (reg_addr == ADDR_W'(A_CAUSE0 + k)) reg_rdata[CAUSE_W-1:0] = cause_q[k];
      if (reg_addr == ADDR_W'(A_CMASK0 + k)) reg_rdata[CAUSE_W-1:0] = chmask_q[k];
    end
  end
endmodule

// File: rtl/otg_irq_status_chk.sv
`timescale 1ns/1ps
module otg_irq_status_chk #(
  parameter int ADDR_W = 6,
  parameter int Q_W    = 4
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic              host_mode,
  input logic              host_rwake_pulse,
  input logic              host_sreq_pulse,
  input logic              disconn_pulse,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [Q_W-1:0]    pq_free_slots,
  input logic              ptxe_flag,
  input logic [3:0]        sticky_bits,
  input logic              ctl_en_q,
  input logic              irq
);
  logic clr_disc;
  assign clr_disc = reg_we && (reg_addr == '0) && reg_wdata[29];

  p_wake_host_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (host_mode && host_rwake_pulse) |=> sticky_bits[3]);

  p_sess_host_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (host_mode && host_sreq_pulse) |=> sticky_bits[2]);

  p_disc_set_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    disconn_pulse |=> sticky_bits[1]);

  p_w1c_clear_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clr_disc && !disconn_pulse) |=> !sticky_bits[1]);

  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!reg_we && sticky_bits[1]) |=> sticky_bits[1]);

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (clr_disc && disconn_pulse) |=> sticky_bits[1]);

  p_ptxe_queue_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (pq_free_slots == '0) |-> !ptxe_flag);

  p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_addr == '0) |-> (reg_rdata[27] == 1'b0 && reg_rdata[24:0] == '0));

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
    !ctl_en_q |=> !irq);
endmodule

bind otg_irq_status otg_irq_status_chk #(.ADDR_W(ADDR_W), .Q_W(Q_W)) u_chk (
  .clk              (clk),
  .core_rst_n       (core_rst_n),
  .host_mode        (host_mode),
  .host_rwake_pulse (host_rwake_pulse),
  .host_sreq_pulse  (host_sreq_pulse),
  .disconn_pulse    (disconn_pulse),
  .reg_we           (reg_we),
  .reg_addr         (reg_addr),
  .reg_wdata        (reg_wdata),
  .reg_rdata        (reg_rdata),
  .pq_free_slots    (pq_free_slots),
  .ptxe_flag        (ptxe_flag),
  .sticky_bits      (sticky_bits),
  .ctl_en_q         (ctl_en_q),
  .irq              (irq)
);

// File: tb/otg_irq_status_test.sv
`timescale 1ns/1ps
module otg_irq_status_test;
  localparam int NCH = 8;
  localparam int CW  = 8;
  localparam int DEPTH = 256;
  localparam int PQD = 8;
  localparam int AW  = 6;
  localparam int LW  = $clog2(DEPTH + 1);
  localparam int QW  = $clog2(PQD + 1);
  localparam int A_CAUSE0 = 4;
  localparam int A_CMASK0 = 4 + NCH;

  // vector: host_mode | pulses{dev_resume,host_rwake,host_sreq,disconn} | b_valid | conn_id
  //         | do_write | write bits 31:28 | expected bits 31:28
  localparam int NV = 21;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000},
    {1'b0, 4'b1000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b1000},
    {1'b0, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b1000, 4'b0000},
    {1'b1, 4'b1000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000},
    {1'b1, 4'b0100, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b1000},
    {1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b1000},
    {1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b1000},
    {1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b1000},
    {1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b1100},
    {1'b1, 4'b0010, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b1100},
    {1'b1, 4'b0000, 1'b1, 1'b0, 1'b1, 4'b0100, 4'b1000},
    {1'b0, 4'b0010, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b1000},
    {1'b1, 4'b0010, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b1100},
    {1'b1, 4'b0001, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b1110},
    {1'b1, 4'b0001, 1'b0, 1'b0, 1'b1, 4'b0010, 4'b1110},
    {1'b1, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0010, 4'b1100},
    {1'b1, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b1101},
    {1'b1, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0001, 4'b1100},
    {1'b1, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b1101},
    {1'b1, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b0000, 4'b1101},
    {1'b1, 4'b0000, 1'b0, 1'b0, 1'b1, 4'b1111, 4'b0000}
  };

  logic              clk;
  logic              rst_n;
  logic              host_mode;
  logic              dev_resume_pulse, host_rwake_pulse, host_sreq_pulse;
  logic              b_valid, disconn_pulse, conn_id;
  logic [LW-1:0]     ptx_free_words;
  logic [QW-1:0]     pq_free_slots;
  logic              ptx_lvl_full_sel;
  logic [NCH*CW-1:0] ch_evt;
  logic              reg_we;
  logic [AW-1:0]     reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic              irq;

  otg_irq_status #(
    .NUM_CH(NCH), .CAUSE_W(CW), .PTX_DEPTH(DEPTH), .PQ_DEPTH(PQD), .ADDR_W(AW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
    .dev_resume_pulse(dev_resume_pulse), .host_rwake_pulse(host_rwake_pulse),
    .host_sreq_pulse(host_sreq_pulse), .b_valid(b_valid),
    .disconn_pulse(disconn_pulse), .conn_id(conn_id),
    .ptx_free_words(ptx_free_words), .pq_free_slots(pq_free_slots),
    .ptx_lvl_full_sel(ptx_lvl_full_sel), .ch_evt(ch_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input int a, input logic [31:0] exp);
    reg_addr = AW'(a);
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_addr = AW'(a);
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic ch_pulse(input int ch, input int bitn);
    @(negedge clk);
    ch_evt[ch*CW + bitn] = 1'b1;
    @(negedge clk);
    ch_evt = '0;
  endtask

  initial begin
    rst_n = 1'b0;
    host_mode = 1'b0;
    dev_resume_pulse = 1'b0; host_rwake_pulse = 1'b0; host_sreq_pulse = 1'b0;
    b_valid = 1'b0; disconn_pulse = 1'b0; conn_id = 1'b0;
    ptx_free_words = '0; pq_free_slots = '0; ptx_lvl_full_sel = 1'b0;
    ch_evt = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk_rd("R11 status after reset", 0, 32'h0);
    chk_rd("R11 mask after reset", 1, 32'h0);
    chk_rd("R11 ctl after reset", 2, 32'h0);
    chk_rd("R11 cause3 after reset", A_CAUSE0 + 3, 32'h0);
    chk("R11 irq after reset", {31'b0, irq}, 32'h0);

    // R1/R2/R3/R4/R5/R6: sticky bits through the vector table
    reg_addr = '0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      host_mode        = VEC[i][15];
      dev_resume_pulse = VEC[i][14];
      host_rwake_pulse = VEC[i][13];
      host_sreq_pulse  = VEC[i][12];
      disconn_pulse    = VEC[i][11];
      b_valid          = VEC[i][10];
      conn_id          = VEC[i][9];
      reg_we           = VEC[i][8];
      reg_addr         = '0;
      reg_wdata        = {VEC[i][7:4], 28'h0};
      @(negedge clk);
      dev_resume_pulse = 1'b0; host_rwake_pulse = 1'b0;
      host_sreq_pulse = 1'b0; disconn_pulse = 1'b0;
      reg_we = 1'b0; reg_wdata = '0;
      #1;
      n_chk++;
      if (reg_rdata[31:28] !== VEC[i][3:0]) begin
        n_fail++;
        $display("FAIL R1/R2/R3/R4/R5/R6 vector %0d: act=%b exp=%b", i, reg_rdata[31:28], VEC[i][3:0]);
      end
    end
    b_valid = 1'b0;

    // R7: periodic FIFO empty flag
    pq_free_slots = '0; ptx_free_words = LW'(DEPTH); ptx_lvl_full_sel = 1'b1;
    chk_rd("R7 no queue room", 0, 32'h0);
    pq_free_slots = QW'(1); ptx_lvl_full_sel = 1'b0; ptx_free_words = LW'(DEPTH/2 - 1);
    chk_rd("R7 half threshold below", 0, 32'h0);
    ptx_free_words = LW'(DEPTH/2);
    chk_rd("R7 half threshold met", 0, 32'h0400_0000);
    ptx_lvl_full_sel = 1'b1; ptx_free_words = LW'(DEPTH - 1);
    chk_rd("R7 full threshold below", 0, 32'h0);
    ptx_free_words = LW'(DEPTH);
    chk_rd("R7 full threshold met", 0, 32'h0400_0000);
    pq_free_slots = '0;
    ptx_free_words = '0;

    // R8: channel hierarchy
    wr(A_CMASK0 + 3, 32'h01);
    ch_pulse(3, 0);
    chk_rd("R8 all-channels ch3", 3, 32'h08);
    chk_rd("R8 status chan bit", 0, 32'h0200_0000);
    chk_rd("R8 cause3", A_CAUSE0 + 3, 32'h01);
    ch_pulse(5, 1);
    chk_rd("R8 cause5 masked", A_CAUSE0 + 5, 32'h02);
    chk_rd("R8 all-channels ch5 masked", 3, 32'h08);

    // R9: read-only and reserved bits ignore writes
    wr(0, 32'hFFFF_FFFF);
    chk_rd("R9 status after all-ones write", 0, 32'h0200_0000);
    wr(3, 32'hFFFF_FFFF);
    chk_rd("R9 all-channels after write", 3, 32'h08);

    // R8: set wins on a cause bit
    @(negedge clk);
    ch_evt[3*CW + 0] = 1'b1;
    reg_we = 1'b1; reg_addr = AW'(A_CAUSE0 + 3); reg_wdata = 32'h01;
    @(negedge clk);
    ch_evt = '0; reg_we = 1'b0; reg_wdata = '0;
    chk_rd("R8 cause set wins", A_CAUSE0 + 3, 32'h01);
    wr(A_CAUSE0 + 3, 32'h01);
    chk_rd("R8 cause cleared", A_CAUSE0 + 3, 32'h0);
    chk_rd("R8 status chan cleared", 0, 32'h0);
    wr(A_CMASK0 + 5, 32'h02);
    chk_rd("R8 unmask ch5", 3, 32'h20);
    wr(A_CAUSE0 + 5, 32'h02);
    chk_rd("R8 ch5 cleared", 3, 32'h0);

    // R10: interrupt line
    wr(1, 32'hFFFF_FFFF);
    chk_rd("R10 mask implemented bits", 1, 32'hF600_0000);
    wr(1, 32'h2000_0000);
    @(negedge clk); disconn_pulse = 1'b1;
    @(negedge clk); disconn_pulse = 1'b0;
    @(negedge clk);
    chk("R10 irq gated off", {31'b0, irq}, 32'h0);
    wr(2, 32'h1);
    @(negedge clk);
    chk("R10 irq enabled", {31'b0, irq}, 32'h1);
    wr(0, 32'h2000_0000);
    @(negedge clk);
    chk("R10 irq after clear", {31'b0, irq}, 32'h0);
    @(negedge clk); conn_id = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 unmasked source", {31'b0, irq}, 32'h0);
    wr(1, 32'h0400_0000);
    ptx_free_words = LW'(DEPTH); pq_free_slots = QW'(2); ptx_lvl_full_sel = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 irq from fifo flag", {31'b0, irq}, 32'h1);
    pq_free_slots = '0;
    repeat (2) @(negedge clk);
    chk("R10 irq fifo flag dropped", {31'b0, irq}, 32'h0);

    // R11: reset in the middle of activity
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_rd("R11 status in reset", 0, 32'h0);
    chk_rd("R11 mask in reset", 1, 32'h0);
    chk_rd("R11 ctl in reset", 2, 32'h0);
    chk_rd("R11 cmask ch5 in reset", A_CMASK0 + 5, 32'h0);
    chk("R11 irq in reset", {31'b0, irq}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_rd("R4 no change flagged after reset", 0, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule